// File: doc/BRIEF.md
# Port Power-Good and Status Tracker

This block holds the per-port state of a power-sourcing controller that serves several ports, four by default. For each port it keeps the latest detection and classification result codes in a status byte, and it keeps a power-enable flag and a power-good flag. It records every change of either flag in a sticky event bit. A protection switch makes the block refuse to power up any port whose classification ended in the current-limit code.

Power-good is qualified. A counter measures how long the port's power-good comparator has held true while the port is powered. When the startup period ends, power-good is granted only if that counter has reached a parameter number of cycles. Once granted, power-good is withdrawn on the next clock edge after the comparator drops, a fault is reported or the port is turned off. Software clears event bits with a masked write-one-to-clear access or with a clear-on-read access that clears every event bit.

Top module: `psc_port_tracker`

## Requirements
- R1: While reset is asserted, every status byte, both flag vectors and both event vectors read all zeros.
- R2: A `det_done` pulse stores that port's 3-bit detection code in bits [2:0] of its status byte on the next clock edge. At all other times the field holds its value. Codes: 000 unknown, 001 positive DC supply present, 010 negative DC supply present, 011 high capacitance, 100 low resistance, 101 valid signature, 110 high resistance, 111 open.
- R3: A `cls_done` pulse stores that port's 3-bit class code in bits [6:4] of its status byte on the next edge. Bits 3 and 7 always read 0. Codes: 000 unknown, 001 to 100 classes 1 to 4, 101 and 110 class 0, 111 current limit.
- R4: When `prot_en` is 1 and the stored class code of a port is 111, a power-on request for that port is refused and its power-enable flag stays 0. When `prot_en` is 0, the same request is accepted.
- R5: Power-enable sets on the edge after an accepted `on_req` and clears on the edge after `off_ind`. If both arrive in the same cycle, `off_ind` wins.
- R6: Power-good sets on the edge after a `startup_done` pulse, but only when all of these hold in that cycle: power-enable is 1, `pg_cmp` is 1, there is no fault and no off indication, and the hold counter has already reached QUAL_CYC.
- R7: Power-good clears on the edge after any cycle in which `pg_cmp` is 0, `fault` is 1, `off_ind` is 1 or power-enable is 0.
- R8: Any change of a port's power-enable or power-good flag sets that port's matching event bit on the same edge as the change.
- R9: Event bits stay set until cleared. An `evt_wr` pulse clears the bits selected by the two masks. An `evt_rd_clr` pulse clears all event bits. If a set and a clear fall on the same edge, the set wins.
- R10: The hold counter restarts from zero in any cycle in which the port is unpowered, `pg_cmp` is 0, or a fault or off indication is present. It counts up by one in each other cycle and saturates at QUAL_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_en | input | 1 | Refuse power-on for current-limit class |
| det_done | input | NPORT | Detection phase finished, per port |
| det_code | input | 3*NPORT | Detection result codes, port p at [3p+2:3p] |
| cls_done | input | NPORT | Classification phase finished, per port |
| cls_code | input | 3*NPORT | Class result codes, port p at [3p+2:3p] |
| on_req | input | NPORT | Power-on request |
| off_ind | input | NPORT | Port turned off |
| fault | input | NPORT | Port fault |
| pg_cmp | input | NPORT | Power-good comparator result |
| startup_done | input | NPORT | End of startup period strobe |
| evt_wr | input | 1 | Write-one-to-clear strobe for event bits |
| pe_evt_clr | input | NPORT | Clear mask for power-enable events |
| pg_evt_clr | input | NPORT | Clear mask for power-good events |
| evt_rd_clr | input | 1 | Clear-on-read strobe, clears all events |
| port_status | output | 8*NPORT | Status byte per port, port p at [8p+7:8p] |
| pwr_en | output | NPORT | Power-enable flags |
| pwr_good | output | NPORT | Power-good flags |
| pe_evt | output | NPORT | Power-enable change events |
| pg_evt | output | NPORT | Power-good change events |

## Verification
Every result is due one clock edge after the stimulus that causes it. A status field follows its done strobe by one edge. A flag follows the request, strobe, fault or comparator drop by one edge. An event bit rises on the same edge as the flag change it records. Inputs are driven on the falling edge, and a bench model advances one step per rising edge. The outputs are compared on the following falling edge, so each check sees exactly one register stage of latency. The two-flop reset synchronizer is covered by idle cycles before any stimulus is applied.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;

  // class code that reports an overcurrent during classification
  localparam code_t CLS_ILIM = 3'b111;

  function automatic logic [7:0] pack_status(code_t det, code_t cls);
    return {1'b0, cls, 1'b0, det};
  endfunction
endpackage

// File: rtl/psc_status_reg.sv
module psc_status_reg
  import psc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  det_done,
  input  code_t det_code,
  input  logic  cls_done,
  input  code_t cls_code,
  output code_t det_q,
  output code_t cls_q
);
  code_t det_d, cls_d;

  always_comb begin
    det_d = det_q;
    cls_d = cls_q;
    if (det_done) det_d = det_code;
    if (cls_done) cls_d = cls_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= '0;
      cls_q <= '0;
    end else begin
      det_q <= det_d;
      cls_q <= cls_d;
    end
  end

  a_r2_det_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !det_done |=> $stable(det_q));
  a_r3_cls_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_done |=> $stable(cls_q));
endmodule

// File: rtl/psc_power_fsm.sv
module psc_power_fsm
  import psc_pkg::*;
#(
  parameter int QUAL_CYC = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  prot_en,
  input  code_t cls_q,
  input  logic  on_req,
  input  logic  off_ind,
  input  logic  fault,
  input  logic  pg_cmp,
  input  logic  startup_done,
  output logic  pe_q,
  output logic  pg_q,
  output logic  pe_d,
  output logic  pg_d
);
  localparam int CNT_W = $clog2(QUAL_CYC + 1);
  localparam logic [CNT_W-1:0] QUAL_MAX = CNT_W'(QUAL_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic refuse, hold, qualified;

  always_comb begin
    refuse    = prot_en && (cls_q == CLS_ILIM);
    hold      = pe_q && pg_cmp && !fault && !off_ind;
    qualified = (cnt_q == QUAL_MAX);

    pe_d = pe_q;
    if (off_ind)               pe_d = 1'b0;
    else if (on_req && !refuse) pe_d = 1'b1;

    cnt_d = '0;
    if (hold) cnt_d = qualified ? cnt_q : cnt_q + CNT_W'(1);

    pg_d = pg_q;
    if (!hold)                          pg_d = 1'b0;
    else if (startup_done && qualified) pg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q  <= 1'b0;
      pg_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      pe_q  <= pe_d;
      pg_q  <= pg_d;
      cnt_q <= cnt_d;
    end
  end

  a_r4_refuse_ilim: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_en && cls_q == CLS_ILIM && !pe_q) |=> !pe_q);
  a_r5_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
    off_ind |=> !pe_q);
  a_r6_rise_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_q) |-> $past(startup_done));
  a_r6_pg_needs_pe: assert property (@(posedge clk) disable iff (!rst_n)
    pg_q |-> pe_q);
  a_r7_fault_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || !pg_cmp) |=> !pg_q);
  a_r10_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_cmp |=> (cnt_q == '0));
endmodule

// File: rtl/psc_event_reg.sv
module psc_event_reg #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] pe_cur,
  input  logic [NPORT-1:0] pe_nxt,
  input  logic [NPORT-1:0] pg_cur,
  input  logic [NPORT-1:0] pg_nxt,
  input  logic             evt_wr,
  input  logic [NPORT-1:0] pe_evt_clr,
  input  logic [NPORT-1:0] pg_evt_clr,
  input  logic             evt_rd_clr,
  output logic [NPORT-1:0] pe_evt,
  output logic [NPORT-1:0] pg_evt
);
  logic [NPORT-1:0] pe_mask, pg_mask, pe_evt_d, pg_evt_d;

  always_comb begin
    pe_mask = '0;
    pg_mask = '0;
    if (evt_rd_clr) begin
      pe_mask = '1;
      pg_mask = '1;
    end else if (evt_wr) begin
      pe_mask = pe_evt_clr;
      pg_mask = pg_evt_clr;
    end
    pe_evt_d = (pe_evt & ~pe_mask) | (pe_nxt ^ pe_cur);
    pg_evt_d = (pg_evt & ~pg_mask) | (pg_nxt ^ pg_cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_evt <= '0;
      pg_evt <= '0;
    end else begin
      pe_evt <= pe_evt_d;
      pg_evt <= pg_evt_d;
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    a_r8_pe_change: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_nxt[i] != pe_cur[i]) |=> pe_evt[i]);
    a_r8_pg_change: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_nxt[i] != pg_cur[i]) |=> pg_evt[i]);
    a_r9_pe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_evt[i] && !evt_rd_clr && !(evt_wr && pe_evt_clr[i])) |=> pe_evt[i]);
    a_r9_pg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_evt[i] && !evt_rd_clr && !(evt_wr && pg_evt_clr[i])) |=> pg_evt[i]);
  end
endmodule

// File: rtl/psc_port_tracker.sv
module psc_port_tracker
  import psc_pkg::*;
#(
  parameter int NPORT    = 4,
  parameter int QUAL_CYC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prot_en,
  input  logic [NPORT-1:0]    det_done,
  input  logic [3*NPORT-1:0]  det_code,
  input  logic [NPORT-1:0]    cls_done,
  input  logic [3*NPORT-1:0]  cls_code,
  input  logic [NPORT-1:0]    on_req,
  input  logic [NPORT-1:0]    off_ind,
  input  logic [NPORT-1:0]    fault,
  input  logic [NPORT-1:0]    pg_cmp,
  input  logic [NPORT-1:0]    startup_done,
  input  logic                evt_wr,
  input  logic [NPORT-1:0]    pe_evt_clr,
  input  logic [NPORT-1:0]    pg_evt_clr,
  input  logic                evt_rd_clr,
  output logic [8*NPORT-1:0]  port_status,
  output logic [NPORT-1:0]    pwr_en,
  output logic [NPORT-1:0]    pwr_good,
  output logic [NPORT-1:0]    pe_evt,
  output logic [NPORT-1:0]    pg_evt
);
  logic rst_meta, rst_sync;
  logic [NPORT-1:0] pe_nxt, pg_nxt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    code_t det_q, cls_q;

    psc_status_reg u_stat (
      .clk      (clk),
      .rst_n    (rst_sync),
      .det_done (det_done[p]),
      .det_code (det_code[3*p +: 3]),
      .cls_done (cls_done[p]),
      .cls_code (cls_code[3*p +: 3]),
      .det_q    (det_q),
      .cls_q    (cls_q)
    );

    assign port_status[8*p +: 8] = pack_status(det_q, cls_q);

    psc_power_fsm #(.QUAL_CYC(QUAL_CYC)) u_pwr (
      .clk          (clk),
      .rst_n        (rst_sync),
      .prot_en      (prot_en),
      .cls_q        (cls_q),
      .on_req       (on_req[p]),
      .off_ind      (off_ind[p]),
      .fault        (fault[p]),
      .pg_cmp       (pg_cmp[p]),
      .startup_done (startup_done[p]),
      .pe_q         (pwr_en[p]),
      .pg_q         (pwr_good[p]),
      .pe_d         (pe_nxt[p]),
      .pg_d         (pg_nxt[p])
    );
  end

  psc_event_reg #(.NPORT(NPORT)) u_evt (
    .clk        (clk),
    .rst_n      (rst_sync),
    .pe_cur     (pwr_en),
    .pe_nxt     (pe_nxt),
    .pg_cur     (pwr_good),
    .pg_nxt     (pg_nxt),
    .evt_wr     (evt_wr),
    .pe_evt_clr (pe_evt_clr),
    .pg_evt_clr (pg_evt_clr),
    .evt_rd_clr (evt_rd_clr),
    .pe_evt     (pe_evt),
    .pg_evt     (pg_evt)
  );

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync |=> (pwr_en == '0 && pwr_good == '0));
endmodule

// File: tb/tb_psc_port_tracker.sv
module tb_psc_port_tracker;
  localparam int NP = 4;
  localparam int QC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prot_en = 1'b0;
  logic [NP-1:0] det_done = '0, cls_done = '0, on_req = '0, off_ind = '0;
  logic [NP-1:0] fault = '0, pg_cmp = '0, startup_done = '0;
  logic [NP-1:0] pe_evt_clr = '0, pg_evt_clr = '0;
  logic [3*NP-1:0] det_code = '0, cls_code = '0;
  logic evt_wr = 1'b0, evt_rd_clr = 1'b0;
  logic [8*NP-1:0] port_status;
  logic [NP-1:0] pwr_en, pwr_good, pe_evt, pg_evt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [2:0] m_det [NP];
  logic [2:0] m_cls [NP];
  logic [NP-1:0] m_pe, m_pg, m_pee, m_pge;
  int m_cnt [NP];

  always #5 clk = ~clk;

  psc_port_tracker #(.NPORT(NP), .QUAL_CYC(QC)) dut (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
    .det_done(det_done), .det_code(det_code),
    .cls_done(cls_done), .cls_code(cls_code),
    .on_req(on_req), .off_ind(off_ind), .fault(fault), .pg_cmp(pg_cmp),
    .startup_done(startup_done), .evt_wr(evt_wr), .pe_evt_clr(pe_evt_clr),
    .pg_evt_clr(pg_evt_clr), .evt_rd_clr(evt_rd_clr),
    .port_status(port_status), .pwr_en(pwr_en), .pwr_good(pwr_good),
    .pe_evt(pe_evt), .pg_evt(pg_evt)
  );

  function automatic bit refused(logic pen, logic [2:0] cls);
    return pen && (cls == 3'b111);
  endfunction

  function automatic logic [7:0] status_byte(logic [2:0] d, logic [2:0] c);
    return {1'b0, c, 1'b0, d};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_det[p] = '0; m_cls[p] = '0; m_cnt[p] = 0;
    end
    m_pe = '0; m_pg = '0; m_pee = '0; m_pge = '0;
  endtask

  // advance one clock; inputs were set at the preceding falling edge
  task automatic step(string pe_tag, string pg_tag);
    logic [2:0] nd [NP];
    logic [2:0] nc [NP];
    int ncnt [NP];
    logic [NP-1:0] npe, npg, cpe, cpg;
    logic [8*NP-1:0] exp_st;
    for (int p = 0; p < NP; p++) begin
      bit hold;
      nd[p] = det_done[p] ? det_code[3*p +: 3] : m_det[p];
      nc[p] = cls_done[p] ? cls_code[3*p +: 3] : m_cls[p];
      npe[p] = m_pe[p];
      if (off_ind[p]) npe[p] = 1'b0;
      else if (on_req[p] && !refused(prot_en, m_cls[p])) npe[p] = 1'b1;
      hold = m_pe[p] && pg_cmp[p] && !fault[p] && !off_ind[p];
      ncnt[p] = hold ? ((m_cnt[p] < QC) ? m_cnt[p] + 1 : QC) : 0;
      npg[p] = m_pg[p];
      if (!hold) npg[p] = 1'b0;
      else if (startup_done[p] && m_cnt[p] == QC) npg[p] = 1'b1;
    end
    cpe = evt_rd_clr ? '1 : (evt_wr ? pe_evt_clr : '0);
    cpg = evt_rd_clr ? '1 : (evt_wr ? pg_evt_clr : '0);
    m_pee = (m_pee & ~cpe) | (npe ^ m_pe);
    m_pge = (m_pge & ~cpg) | (npg ^ m_pg);
    m_pe = npe; m_pg = npg;
    for (int p = 0; p < NP; p++) begin
      m_det[p] = nd[p]; m_cls[p] = nc[p]; m_cnt[p] = ncnt[p];
      exp_st[8*p +: 8] = status_byte(nd[p], nc[p]);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2 R3 status", 32'(port_status), 32'(exp_st));
    chk(pe_tag, 32'(pwr_en), 32'(m_pe));
    chk(pg_tag, 32'(pwr_good), 32'(m_pg));
    chk("R8 R9 pe events", 32'(pe_evt), 32'(m_pee));
    chk("R8 R9 pg events", 32'(pg_evt), 32'(m_pge));
  endtask

  task automatic idle_inputs();
    det_done = '0; cls_done = '0; on_req = '0; off_ind = '0; fault = '0;
    startup_done = '0; evt_wr = 1'b0; evt_rd_clr = 1'b0;
    pe_evt_clr = '0; pg_evt_clr = '0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: everything zero while in reset
    chk("R1 status", 32'(port_status), 32'h0);
    chk("R1 flags", 32'({pwr_en, pwr_good}), 32'h0);
    chk("R1 events", 32'({pe_evt, pg_evt}), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3: latch codes on port 0 and 2
    det_done = 4'b0101; det_code = 12'o5_0_3_0 ; det_code[2:0] = 3'b101;
    cls_done = 4'b0001; cls_code = '0; cls_code[2:0] = 3'b111;
    step("R5", "R6");
    idle_inputs();
    chk("R2 det port0", 32'(port_status[2:0]), 32'h5);
    chk("R3 cls port0", 32'(port_status[6:4]), 32'h7);

    // R4: current-limit class refused while protection is on
    prot_en = 1'b1; on_req = 4'b0001;
    step("R4 refused", "R6");
    idle_inputs();
    chk("R4 pe stays low", 32'(pwr_en[0]), 32'h0);
    prot_en = 1'b0; on_req = 4'b0001;
    step("R4 accepted", "R6");
    idle_inputs();
    chk("R4 pe set without protection", 32'(pwr_en[0]), 32'h1);

    // R5: off wins over on
    on_req = 4'b0010; off_ind = 4'b0010;
    step("R5 off wins", "R6");
    idle_inputs();
    chk("R5 off wins", 32'(pwr_en[1]), 32'h0);

    // R6 R10: qualification on port 0
    pg_cmp = 4'b0001;
    step("R5", "R10"); step("R5", "R10");
    startup_done = 4'b0001;
    step("R5", "R6 too early");
    idle_inputs();
    chk("R6 too early", 32'(pwr_good[0]), 32'h0);
    pg_cmp = 4'b0000; step("R5", "R10 drop");
    pg_cmp = 4'b0001;
    for (int i = 0; i < QC - 1; i++) step("R5", "R10");
    startup_done = 4'b0001;
    step("R5", "R10 restart");
    idle_inputs();
    chk("R10 restarted counter not ready", 32'(pwr_good[0]), 32'h0);
    step("R5", "R6");
    startup_done = 4'b0001;
    step("R5", "R6 qualified");
    idle_inputs();
    chk("R6 qualified", 32'(pwr_good[0]), 32'h1);
    chk("R8 pg event", 32'(pg_evt[0]), 32'h1);

    // R9: masked write clears only chosen bits; read clear clears all
    evt_wr = 1'b1; pe_evt_clr = 4'b0001;
    step("R5", "R6");
    idle_inputs();
    chk("R9 write clear", 32'({pe_evt[0], pg_evt[0]}), 32'h1);

    // R7: fault kills power-good at once
    fault = 4'b0001;
    step("R5", "R7 fault");
    idle_inputs();
    chk("R7 fault kill", 32'(pwr_good[0]), 32'h0);
    evt_rd_clr = 1'b1;
    step("R5", "R7");
    idle_inputs();
    chk("R9 read clear", 32'({pe_evt, pg_evt}), 32'h0);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < NP; p++) begin
        det_done[p] = ($urandom % 8) == 0;
        cls_done[p] = ($urandom % 8) == 0;
        det_code[3*p +: 3] = 3'($urandom);
        cls_code[3*p +: 3] = 3'($urandom);
        on_req[p] = ($urandom % 6) == 0;
        off_ind[p] = ($urandom % 50) == 0;
        fault[p] = ($urandom % 70) == 0;
        if (($urandom % 12) == 0) pg_cmp[p] = ~pg_cmp[p];
        startup_done[p] = ($urandom % 5) == 0;
      end
      if (($urandom % 200) == 0) prot_en = ~prot_en;
      evt_wr = ($urandom % 20) == 0;
      pe_evt_clr = 4'($urandom);
      pg_evt_clr = 4'($urandom);
      evt_rd_clr = ($urandom % 30) == 0;
      step("R5 R4 random", "R6 R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule